// File: doc/BRIEF.md
# Windowed Rolling-Shutter Readout Sequencer

This block produces the readout timing for a rolling-shutter pixel array, one pixel per clock of a pixel-rate clock. It either reads the whole array or a rectangular window of it. Four window registers set the window: first column, first row, number of columns and number of rows. Software writes them through a small parallel write port. The values are held in a staging copy. A shadow copy used by the scan is loaded only when a frame begins.

Each frame opens with a one-cycle frame-start pulse, which loads the row shift register. Every line opens with a one-cycle line clock, which loads the column shift register. A fixed overhead of OVERHEAD clocks follows the line clock. After it, the pixel-valid strobe is high for one cycle per selected column, and the absolute row and column address of each pixel is reported. Frame time is therefore rows × (OVERHEAD + columns) clocks. With the default array of 3002 × 2210, an overhead of 288 and a 25 ns clock, this is 7,498,996 clocks, or about 187.5 ms (5.33 frames per second). Frame time falls almost linearly as the window shrinks.

Column starts are coarse: they snap down to multiples of COL_STEP (24 by default). A row start may be any line. A one-cycle end-of-frame pulse marks the last pixel. While the run enable is high, the next frame begins on the following clock.

Top module: `roi_readout_seq`

## Requirements
- R1: During and after a synchronous reset, frame_start, line_clk, pix_valid and frame_end are low, and row_idx and col_idx are 0. The window registers reset to column start 0, row start 0, column count COLS and row count ROWS.
- R2: frame_start is high for exactly one cycle per frame, and always in the same cycle as the first line_clk of that frame.
- R3: Each line has one line_clk cycle, which is the first of OVERHEAD overhead cycles. pix_valid rises exactly OVERHEAD cycles after line_clk and stays high for column-count consecutive cycles. A frame has row-count lines.
- R4: Pixels come out in row-major order. row_idx equals row start plus the row offset. During pix_valid, col_idx equals column start plus the column offset, and it increments by 1 each cycle within a line.
- R5: Counting from the frame_start cycle to the frame_end cycle inclusive, a frame lasts row_count × (OVERHEAD + column_count) cycles.
- R6: A written column start is rounded down to a multiple of COL_STEP. If the result is COLS or more, it becomes the largest multiple of COL_STEP below COLS.
- R7: A written row start takes any value. A value of ROWS or more becomes ROWS−1.
- R8: A count of 0 is treated as 1. A count is cut down so that start plus count never exceeds COLS (for columns) or ROWS (for rows).
- R9: Window writes made during a frame do not change that frame. They take effect at the next frame_start.
- R10: frame_end is high for one cycle, in the same cycle as the last pixel of the last row. If run is high, the next frame_start follows on the next clock. If run is low, the block stays idle, with no line_clk and no pix_valid, until run rises. The write port selects the register with wr_sel: 0 is column start, 1 is row start, 2 is column count and 3 is row count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Continuous-run enable; starts a frame from idle and chains frames |
| wr_en | input | 1 | Window register write strobe |
| wr_sel | input | 2 | Register select: 0 column start, 1 row start, 2 column count, 3 row count |
| wr_data | input | DW | Write data |
| frame_start | output | 1 | One-cycle pulse that loads the row shift register |
| line_clk | output | 1 | One-cycle pulse per line that loads the column shift register |
| pix_valid | output | 1 | High for each output pixel |
| frame_end | output | 1 | One-cycle pulse on the last pixel of a frame |
| row_idx | output | RW | Absolute row address of the current line |
| col_idx | output | CW | Absolute column address, valid with pix_valid |

## Verification
The assertions check the following on every cycle:
- frame_start always falls on a line_clk, and a line_clk never lasts two cycles.
- Within a line, col_idx steps by one while row_idx holds.
- Every line starts at a column aligned to COL_STEP, and every pixel address lies inside the array.
- frame_end falls on a valid pixel and is followed by a cycle without one.

Only the bench scenarios can show the rest:
- the exact pixel sequence of each window;
- the rounding and clipping of written values;
- the frame and overhead lengths;
- the deferral of mid-frame writes to the next frame;
- the one-clock gap between chained frames;
- the silence after run drops.

// File: rtl/roi_seq_pkg.sv
package roi_seq_pkg;

  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_OVH  = 2'd1,
    SCAN_ACT  = 2'd2
  } scan_state_e;

  typedef enum logic [1:0] {
    WSEL_COL_START = 2'd0,
    WSEL_ROW_START = 2'd1,
    WSEL_COL_COUNT = 2'd2,
    WSEL_ROW_COUNT = 2'd3
  } wsel_e;

endpackage

// File: rtl/roi_win_regs.sv
module roi_win_regs
  import roi_seq_pkg::*;
#(
  parameter int ROWS     = 3002,
  parameter int COLS     = 2210,
  parameter int COL_STEP = 24,
  parameter int DW       = 16,
  parameter int RW       = $clog2(ROWS + 1),
  parameter int CW       = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          load,
  output logic [CW-1:0] col_s,
  output logic [RW-1:0] row_s,
  output logic [CW-1:0] col_n,
  output logic [RW-1:0] row_n
);

  localparam int MAX_CS = ((COLS - 1) / COL_STEP) * COL_STEP;
  localparam int MAX_RS = ROWS - 1;

  // staging copy, starts already clipped
  logic [CW-1:0] stg_cs;
  logic [RW-1:0] stg_rs;
  logic [DW-1:0] stg_cc;
  logic [DW-1:0] stg_rc;

  logic [CW-1:0] cs_wr;
  logic [RW-1:0] rs_wr;
  logic [CW-1:0] cc_eff;
  logic [RW-1:0] rc_eff;

  always_comb begin
    int v;
    v = (int'(wr_data) / COL_STEP) * COL_STEP;
    if (v > MAX_CS) v = MAX_CS;
    cs_wr = CW'(v);
  end

  always_comb begin
    int v;
    v = int'(wr_data);
    if (v > MAX_RS) v = MAX_RS;
    rs_wr = RW'(v);
  end

  // counts are fitted to the staged starts when the shadow loads
  always_comb begin
    int avail;
    int v;
    avail = COLS - int'(stg_cs);
    v = int'(stg_cc);
    if (v == 0) v = 1;
    if (v > avail) v = avail;
    cc_eff = CW'(v);
  end

  always_comb begin
    int avail;
    int v;
    avail = ROWS - int'(stg_rs);
    v = int'(stg_rc);
    if (v == 0) v = 1;
    if (v > avail) v = avail;
    rc_eff = RW'(v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_cs <= '0;
      stg_rs <= '0;
      stg_cc <= DW'(COLS);
      stg_rc <= DW'(ROWS);
    end else if (wr_en) begin
      case (wsel_e'(wr_sel))
        WSEL_COL_START: stg_cs <= cs_wr;
        WSEL_ROW_START: stg_rs <= rs_wr;
        WSEL_COL_COUNT: stg_cc <= wr_data;
        default:        stg_rc <= wr_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_s <= '0;
      row_s <= '0;
      col_n <= CW'(COLS);
      row_n <= RW'(ROWS);
    end else if (load) begin
      col_s <= stg_cs;
      row_s <= stg_rs;
      col_n <= cc_eff;
      row_n <= rc_eff;
    end
  end

endmodule

// File: rtl/roi_scan_fsm.sv
module roi_scan_fsm
  import roi_seq_pkg::*;
#(
  parameter int OVERHEAD = 288,
  parameter int RW       = 12,
  parameter int CW       = 12,
  parameter int CNT_W    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CW-1:0]    col_n,
  input  logic [RW-1:0]    row_n,
  output scan_state_e      st,
  output logic [CNT_W-1:0] cnt,
  output logic [RW-1:0]    row_off,
  output logic             line_last,
  output logic             frame_last,
  output logic             load
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [RW-1:0]    ROW_ONE  = RW'(1);
  localparam logic [CNT_W-1:0] OVH_LAST = CNT_W'(OVERHEAD - 1);

  assign line_last  = (st == SCAN_ACT) && (cnt == (CNT_W'(col_n) - CNT_ONE));
  assign frame_last = line_last && (row_off == (row_n - ROW_ONE));
  assign load       = run && ((st == SCAN_IDLE) || frame_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SCAN_IDLE;
      cnt     <= '0;
      row_off <= '0;
    end else begin
      case (st)
        SCAN_IDLE: begin
          if (run) begin
            st      <= SCAN_OVH;
            cnt     <= '0;
            row_off <= '0;
          end
        end
        SCAN_OVH: begin
          if (cnt == OVH_LAST) begin
            st  <= SCAN_ACT;
            cnt <= '0;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        SCAN_ACT: begin
          if (frame_last) begin
            st      <= run ? SCAN_OVH : SCAN_IDLE;
            cnt     <= '0;
            row_off <= '0;
          end else if (line_last) begin
            st      <= SCAN_OVH;
            cnt     <= '0;
            row_off <= row_off + ROW_ONE;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        default: st <= SCAN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/roi_out_stage.sv
module roi_out_stage
  import roi_seq_pkg::*;
#(
  parameter int RW    = 12,
  parameter int CW    = 12,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  scan_state_e      st,
  input  logic [CNT_W-1:0] cnt,
  input  logic [RW-1:0]    row_off,
  input  logic             frame_last,
  input  logic [CW-1:0]    col_s,
  input  logic [RW-1:0]    row_s,
  output logic             frame_start,
  output logic             line_clk,
  output logic             pix_valid,
  output logic             frame_end,
  output logic [RW-1:0]    row_idx,
  output logic [CW-1:0]    col_idx
);

  logic first_ovh;
  assign first_ovh = (st == SCAN_OVH) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_start <= 1'b0;
      line_clk    <= 1'b0;
      pix_valid   <= 1'b0;
      frame_end   <= 1'b0;
      row_idx     <= '0;
      col_idx     <= '0;
    end else begin
      frame_start <= first_ovh && (row_off == '0);
      line_clk    <= first_ovh;
      pix_valid   <= (st == SCAN_ACT);
      frame_end   <= frame_last;
      if (st == SCAN_IDLE) begin
        row_idx <= '0;
        col_idx <= '0;
      end else begin
        row_idx <= row_s + row_off;
        col_idx <= (st == SCAN_ACT) ? (col_s + cnt[CW-1:0]) : col_s;
      end
    end
  end

endmodule

// File: rtl/roi_readout_seq.sv
module roi_readout_seq
  import roi_seq_pkg::*;
#(
  parameter int ROWS     = 3002,
  parameter int COLS     = 2210,
  parameter int OVERHEAD = 288,
  parameter int COL_STEP = 24,
  parameter int DW       = 16,
  parameter int RW       = $clog2(ROWS + 1),
  parameter int CW       = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          frame_start,
  output logic          line_clk,
  output logic          pix_valid,
  output logic          frame_end,
  output logic [RW-1:0] row_idx,
  output logic [CW-1:0] col_idx
);

  localparam int CNT_MAX = (OVERHEAD > COLS) ? OVERHEAD : COLS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CW-1:0]    col_s;
  logic [RW-1:0]    row_s;
  logic [CW-1:0]    col_n;
  logic [RW-1:0]    row_n;
  scan_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic [RW-1:0]    row_off;
  logic             line_last;
  logic             frame_last;
  logic             load;

  roi_win_regs #(
    .ROWS(ROWS), .COLS(COLS), .COL_STEP(COL_STEP), .DW(DW), .RW(RW), .CW(CW)
  ) u_win (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .load(load), .col_s(col_s), .row_s(row_s), .col_n(col_n), .row_n(row_n)
  );

  roi_scan_fsm #(
    .OVERHEAD(OVERHEAD), .RW(RW), .CW(CW), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .run(run), .col_n(col_n), .row_n(row_n),
    .st(st), .cnt(cnt), .row_off(row_off), .line_last(line_last),
    .frame_last(frame_last), .load(load)
  );

  roi_out_stage #(
    .RW(RW), .CW(CW), .CNT_W(CNT_W)
  ) u_out (
    .clk(clk), .rst(rst), .st(st), .cnt(cnt), .row_off(row_off),
    .frame_last(frame_last), .col_s(col_s), .row_s(row_s),
    .frame_start(frame_start), .line_clk(line_clk), .pix_valid(pix_valid),
    .frame_end(frame_end), .row_idx(row_idx), .col_idx(col_idx)
  );

endmodule

// File: rtl/roi_readout_seq_chk.sv
module roi_readout_seq_chk #(
  parameter int ROWS     = 3002,
  parameter int COLS     = 2210,
  parameter int COL_STEP = 24,
  parameter int RW       = 12,
  parameter int CW       = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic          line_clk,
  input logic          pix_valid,
  input logic          frame_end,
  input logic [RW-1:0] row_idx,
  input logic [CW-1:0] col_idx
);

  // R2
  fs_on_line_clk_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_clk);

  // R3
  line_clk_single_chk: assert property (@(posedge clk) disable iff (rst)
    line_clk |=> !line_clk);

  // R4
  col_step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(pix_valid)) |-> (col_idx == $past(col_idx) + CW'(1)));

  // R4
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(pix_valid)) |-> $stable(row_idx));

  // R6
  col_align_chk: assert property (@(posedge clk) disable iff (rst)
    line_clk |-> ((int'(col_idx) % COL_STEP) == 0));

  // R8
  in_array_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> ((int'(col_idx) < COLS) && (int'(row_idx) < ROWS)));

  // R10
  fe_on_pixel_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> pix_valid);

  // R10
  fe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (!pix_valid && !frame_end));

endmodule

bind roi_readout_seq roi_readout_seq_chk #(
  .ROWS(ROWS), .COLS(COLS), .COL_STEP(COL_STEP), .RW(RW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .line_clk(line_clk),
  .pix_valid(pix_valid), .frame_end(frame_end), .row_idx(row_idx),
  .col_idx(col_idx)
);

// File: tb/roi_readout_seq_bench.sv
`timescale 1ns/1ps
module roi_readout_seq_bench;

  localparam int ROWS = 20;
  localparam int COLS = 96;
  localparam int OVH  = 8;
  localparam int STEP = 24;
  localparam int DW   = 16;
  localparam int RW   = $clog2(ROWS + 1);
  localparam int CW   = $clog2(COLS + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic          frame_start, line_clk, pix_valid, frame_end;
  logic [RW-1:0] row_idx;
  logic [CW-1:0] col_idx;

  always #2.5 clk = ~clk;

  roi_readout_seq #(
    .ROWS(ROWS), .COLS(COLS), .OVERHEAD(OVH), .COL_STEP(STEP), .DW(DW)
  ) u_roi_readout_seq (
    .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .frame_start(frame_start), .line_clk(line_clk),
    .pix_valid(pix_valid), .frame_end(frame_end), .row_idx(row_idx),
    .col_idx(col_idx)
  );

  typedef struct {int r; int c;} pix_t;
  pix_t pq[$];
  int   perq[$];

  int n_chk = 0;
  int n_fail = 0;
  int exp_lines = 0;
  int lines = 0;
  int cyc = 0;
  int fs_cyc = 0;
  int fe_cyc = 0;
  int fs_count = 0;
  int fe_count = 0;
  int since_lc = 0;
  bit waiting_pix = 0;
  bit expect_b2b = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver side: expected pixels and frame length from the requirements
  task automatic push_frame(input int cs, input int rs, input int cc, input int rc);
    int ecs, ers, ecc, erc;
    ecs = (cs / STEP) * STEP;                          // R6
    if (ecs >= COLS) ecs = ((COLS - 1) / STEP) * STEP;
    ers = (rs >= ROWS) ? ROWS - 1 : rs;                // R7
    ecc = (cc == 0) ? 1 : cc;                          // R8
    if (ecc > COLS - ecs) ecc = COLS - ecs;
    erc = (rc == 0) ? 1 : rc;
    if (erc > ROWS - ers) erc = ROWS - ers;
    for (int r = 0; r < erc; r++)
      for (int c = 0; c < ecc; c++) begin
        pix_t p;
        p.r = ers + r;
        p.c = ecs + c;
        pq.push_back(p);
      end
    perq.push_back(erc * (OVH + ecc));
    exp_lines += erc;
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_sel  = 2'(sel);
    wr_data = DW'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_win(input int cs, input int rs, input int cc, input int rc);
    wr(0, cs); wr(1, rs); wr(2, cc); wr(3, rc);
  endtask

  task automatic wait_fs();
    int p;
    p = fs_count;
    while (fs_count == p) @(negedge clk);
  endtask

  task automatic wait_fe();
    int p;
    p = fe_count;
    while (fe_count == p) @(negedge clk);
  endtask

  task automatic one_frame();
    @(negedge clk);
    run = 1'b1;
    wait_fs();
    run = 1'b0;
    wait_fe();
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares DUT output against the scoreboard queues
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (line_clk) begin
        since_lc = 0;
        waiting_pix = 1;
        lines++;
      end else begin
        since_lc++;
      end
      if (frame_start) begin
        check(line_clk, "R2 frame_start with line_clk", int'(line_clk), 1);
        if (expect_b2b) begin
          check(cyc == fe_cyc + 1, "R10 back-to-back start", cyc - fe_cyc, 1);
          expect_b2b = 0;
        end
        fs_cyc = cyc;
        fs_count++;
      end
      if (pix_valid) begin
        if (waiting_pix) begin
          check(since_lc == OVH, "R3 overhead length", since_lc, OVH);
          waiting_pix = 0;
        end
        if (pq.size() == 0) begin
          check(0, "R10 unexpected pixel", int'(row_idx), -1);
        end else begin
          pix_t e;
          e = pq.pop_front();
          check(int'(row_idx) == e.r, "R4 row_idx", int'(row_idx), e.r);
          check(int'(col_idx) == e.c, "R4 col_idx", int'(col_idx), e.c);
        end
      end
      if (frame_end) begin
        check(pix_valid, "R10 frame_end on pixel", int'(pix_valid), 1);
        if (perq.size() == 0) begin
          check(0, "R5 unexpected frame_end", cyc - fs_cyc + 1, -1);
        end else begin
          int ep;
          ep = perq.pop_front();
          check(cyc - fs_cyc + 1 == ep, "R5 frame period", cyc - fs_cyc + 1, ep);
        end
        fe_cyc = cyc;
        fe_count++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    check({frame_start, line_clk, pix_valid, frame_end} == 4'b0, "R1 strobes in reset",
          int'({frame_start, line_clk, pix_valid, frame_end}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check({frame_start, line_clk, pix_valid, frame_end} == 4'b0, "R1 strobes after reset",
          int'({frame_start, line_clk, pix_valid, frame_end}), 0);
    check(row_idx == '0 && col_idx == '0, "R1 indices after reset",
          int'(row_idx) + int'(col_idx), 0);

    // R1 R5: full array from reset defaults
    push_frame(0, 0, COLS, ROWS);
    one_frame();

    // R6: column start 30 rounds to 24
    set_win(30, 3, 40, 5);
    push_frame(30, 3, 40, 5);
    one_frame();

    // R8: counts cut at the array edge
    set_win(72, 17, 50, 10);
    push_frame(72, 17, 50, 10);
    one_frame();

    // R6 R7 R8: starts past the array, zero counts
    set_win(200, 50, 0, 0);
    push_frame(200, 50, 0, 0);
    one_frame();

    // R9 R10: mid-frame write deferred, chained frames
    set_win(0, 0, 24, 2);
    push_frame(0, 0, 24, 2);
    push_frame(48, 4, 24, 2);
    @(negedge clk);
    run = 1'b1;
    wait_fs();
    set_win(48, 4, 24, 2);
    expect_b2b = 1;
    wait_fs();
    run = 1'b0;
    wait_fe();

    // R10: idle with run low
    repeat (60) @(negedge clk);
    check(pq.size() == 0, "R4 all pixels seen", pq.size(), 0);
    check(perq.size() == 0, "R5 all frames seen", perq.size(), 0);
    check(lines == exp_lines, "R3 line count", lines, exp_lines);
    check(!pix_valid && !line_clk, "R10 idle after run low",
          int'(pix_valid) + int'(line_clk), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule